// File: doc/BRIEF.md
# Eight-Channel Trigger-Delayed Pulse Generator

This block turns a rising edge on any of its trigger pins into a pulse on the matching output. The pulse comes after a programmable wait. Each channel holds two 32-bit cycle counts: a wait length and a pulse width. Software writes these through a narrow synchronous port made of a write strobe, an address and data. After a trigger is taken, the output stays low for the wait length and then goes high for the pulse width. The channel then returns to idle and can take the next trigger.

Each trigger pin is first brought into the clock domain by two flops. The block then finds rising edges by comparing the synchronised level with a copy delayed by one cycle. No flop is ever clocked by a trigger pin. Each channel runs a three-state machine:

- IDLE waits for an edge.
- WAIT counts the delay.
- PULSE counts the width.

The transitions are:

- IDLE→WAIT when an edge arrives and the delay is nonzero.
- IDLE→PULSE when an edge arrives, the delay is zero and the width is nonzero.
- WAIT→PULSE when the delay count completes and the width is nonzero.
- WAIT→IDLE when the delay count completes and the width is zero.
- PULSE→IDLE when the width count completes.

Top module: `dgg_top`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) returns every channel to IDLE, drives all outputs low and clears all sixteen count registers. A trigger taken after reset therefore produces no pulse.
- R2: A write with `wr_en` high stores `wr_data` on the clock edge. Address 2*ch selects the delay of channel ch and address 2*ch+1 selects its width. No other register changes.
- R3: When a trigger pin is first sampled high at clock edge k after being low at edge k-1, an idle channel accepts the trigger at edge k+2.
- R4: After a trigger is accepted at edge a with delay d and width g, the output is high after exactly the edges a+d through a+d+g-1 and low otherwise.
- R5: Rising trigger edges that reach a channel while it is in WAIT or PULSE are ignored.
- R6: A channel returns to IDLE at edge a+d+g. Any trigger edge it sees after that edge is accepted.
- R7: A width of zero produces no pulse, and the channel returns to IDLE after the delay.
- R8: A channel latches its delay and width when it accepts a trigger. Writes made while it is busy affect only later triggers.
- R9: A trigger pin held high causes only one acceptance. A new low-to-high transition is needed to trigger again.
- R10: Channels run independently. Simultaneous triggers with different counts give each channel its own timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register select (2*ch delay, 2*ch+1 width) |
| wr_data | input | 32 | Count value to store |
| trig_i | input | 8 | Asynchronous trigger pins, one per channel |
| gate_o | output | 8 | Pulse outputs, one per channel |

## Verification
The hardest case to reach from the ports is a second trigger edge that arrives in the very cycle the channel returns to IDLE, or the cycle just after it. Because of the three-cycle synchroniser latency, this happens only when the second pin pulse is placed at an exact offset from the first. The stimulus sweeps the gap between two trigger pulses over every offset from one cycle to well past the pulse end. A cycle-by-cycle reference model shows which offsets must be taken and which must be ignored. Writes issued during the WAIT phase are also timed so that the latched and the updated counts give different waveforms.

// File: rtl/dgg_pkg.sv
package dgg_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_WAIT  = 2'd1,
        CH_PULSE = 2'd2
    } ch_state_e;

endpackage

// File: rtl/dgg_trig_sync.sv
module dgg_trig_sync #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] pin_i,
    output logic [NCH-1:0] rise_o
);
    logic [NCH-1:0] meta_q;
    logic [NCH-1:0] level_q;
    logic [NCH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q  <= '0;
            level_q <= '0;
            prev_q  <= '0;
        end else begin
            meta_q  <= pin_i;
            level_q <= meta_q;
            prev_q  <= level_q;
        end
    end

    // Rising edge: synchronised level high, one-cycle-old copy low.
    assign rise_o = level_q & ~prev_q;
endmodule

// File: rtl/dgg_regs.sv
module dgg_regs #(
    parameter int NCH    = 8,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [CNT_W-1:0]           wr_data,
    output logic [NCH-1:0][CNT_W-1:0]  dly_o,
    output logic [NCH-1:0][CNT_W-1:0]  wid_o
);
    for (genvar ch = 0; ch < NCH; ch++) begin : g_reg
        localparam logic [ADDR_W-1:0] DLY_ADDR = ADDR_W'(2 * ch);
        localparam logic [ADDR_W-1:0] WID_ADDR = ADDR_W'(2 * ch + 1);

        always_ff @(posedge clk) begin
            if (rst) begin
                dly_o[ch] <= '0;
                wid_o[ch] <= '0;
            end else if (wr_en) begin
                if (wr_addr == DLY_ADDR) dly_o[ch] <= wr_data;
                if (wr_addr == WID_ADDR) wid_o[ch] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/dgg_channel.sv
module dgg_channel
    import dgg_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire_i,
    input  logic [CNT_W-1:0] dly_cfg_i,
    input  logic [CNT_W-1:0] wid_cfg_i,
    output logic             gate_o,
    output logic             busy_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    ch_state_e        state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [CNT_W-1:0] dly_q, dly_n;
    logic [CNT_W-1:0] wid_q, wid_n;

    // Next-state and counter logic
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        dly_n   = dly_q;
        wid_n   = wid_q;
        unique case (state_q)
            CH_IDLE: begin
                if (fire_i) begin
                    dly_n = dly_cfg_i;
                    wid_n = wid_cfg_i;
                    if (dly_cfg_i != '0) begin
                        state_n = CH_WAIT;
                        cnt_n   = ONE;
                    end else if (wid_cfg_i != '0) begin
                        state_n = CH_PULSE;
                        cnt_n   = ONE;
                    end
                end
            end
            CH_WAIT: begin
                if (cnt_q == dly_q) begin
                    if (wid_q != '0) begin
                        state_n = CH_PULSE;
                        cnt_n   = ONE;
                    end else begin
                        state_n = CH_IDLE;
                        cnt_n   = '0;
                    end
                end else begin
                    cnt_n = cnt_q + ONE;
                end
            end
            CH_PULSE: begin
                if (cnt_q == wid_q) begin
                    state_n = CH_IDLE;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_q + ONE;
                end
            end
            default: begin
                state_n = CH_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CH_IDLE;
            cnt_q   <= '0;
            dly_q   <= '0;
            wid_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            dly_q   <= dly_n;
            wid_q   <= wid_n;
        end
    end

    // Outputs
    always_comb begin
        gate_o = (state_q == CH_PULSE);
        busy_o = (state_q != CH_IDLE);
    end
endmodule

// File: rtl/dgg_top.sv
module dgg_top #(
    parameter int NCH    = 8,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = $clog2(2 * NCH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [NCH-1:0]    trig_i,
    output logic [NCH-1:0]    gate_o
);
    logic [NCH-1:0]            fire_w;
    logic [NCH-1:0]            busy_w;
    logic [NCH-1:0][CNT_W-1:0] dly_w;
    logic [NCH-1:0][CNT_W-1:0] wid_w;

    dgg_trig_sync #(.NCH(NCH)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (trig_i),
        .rise_o (fire_w)
    );

    dgg_regs #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .dly_o   (dly_w),
        .wid_o   (wid_w)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        dgg_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .fire_i    (fire_w[ch]),
            .dly_cfg_i (dly_w[ch]),
            .wid_cfg_i (wid_w[ch]),
            .gate_o    (gate_o[ch]),
            .busy_o    (busy_w[ch])
        );
    end
endmodule

// File: rtl/dgg_checker.sv
module dgg_checker #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] fire,
    input logic [NCH-1:0] busy,
    input logic [NCH-1:0] gate
);
    logic rst_q = 1'b0;
    always_ff @(posedge clk) rst_q <= rst;

    always @(negedge clk) begin
        if (rst_q) begin
            p_rst_quiet_r1: assert (gate == '0);
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R4: a pulse starts only from a waiting channel or a fresh trigger
        p_gate_origin_r4: assert property (@(posedge clk) disable iff (rst)
            $rose(gate[i]) |-> $past(busy[i] | fire[i]));
        // R5: a channel becomes busy only on a detected edge
        p_busy_origin_r5: assert property (@(posedge clk) disable iff (rst)
            $rose(busy[i]) |-> $past(fire[i]));
        // R6: end of the pulse leaves the channel idle
        p_gate_end_idle_r6: assert property (@(posedge clk) disable iff (rst)
            $fell(gate[i]) |-> !busy[i]);
        // R9: the edge detector emits single-cycle events
        p_fire_single_r9: assert property (@(posedge clk) disable iff (rst)
            fire[i] |=> !fire[i]);
    end
endmodule

bind dgg_top dgg_checker #(.NCH(NCH)) u_dgg_checker (
    .clk  (clk),
    .rst  (rst),
    .fire (fire_w),
    .busy (busy_w),
    .gate (gate_o)
);

// File: tb/test_dgg_top.sv
module test_dgg_top;
    localparam int NCH    = 8;
    localparam int CNT_W  = 32;
    localparam int ADDR_W = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [CNT_W-1:0]  wr_data = '0;
    logic [NCH-1:0]    trig_r = '0;
    logic [NCH-1:0]    gate_o;

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #5 clk = ~clk;

    dgg_top #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_dgg_top (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .trig_i  (trig_r),
        .gate_o  (gate_o)
    );

    // Reference model, built from the requirement timing
    longint cyc = 0;
    bit     h0 [NCH], h1 [NCH], h2 [NCH], h3 [NCH];
    bit     acc_v [NCH];
    longint acc_c [NCH], ad [NCH], ag [NCH], e_end [NCH];
    longint sh_d [NCH], sh_g [NCH];
    logic [NCH-1:0] exp_q = '0;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst) begin
            for (int i = 0; i < NCH; i++) begin
                h0[i] = 0; h1[i] = 0; h2[i] = 0; h3[i] = 0;
                acc_v[i] = 0; e_end[i] = -1; sh_d[i] = 0; sh_g[i] = 0;
            end
            exp_q = '0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                h3[i] = h2[i]; h2[i] = h1[i]; h1[i] = h0[i]; h0[i] = trig_r[i];
                if (h2[i] && !h3[i] && cyc > e_end[i]) begin
                    acc_v[i] = 1; acc_c[i] = cyc;
                    ad[i] = sh_d[i]; ag[i] = sh_g[i];
                    e_end[i] = cyc + ad[i] + ag[i];
                end
                exp_q[i] = acc_v[i] && (cyc >= acc_c[i] + ad[i]) &&
                           (cyc < acc_c[i] + ad[i] + ag[i]);
            end
            if (wr_en) begin
                if (wr_addr[0]) sh_g[wr_addr[ADDR_W-1:1]] = longint'(wr_data);
                else            sh_d[wr_addr[ADDR_W-1:1]] = longint'(wr_data);
            end
        end
    end

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (gate_o !== exp_q) begin
                failures++;
                $display("FAIL %s cycle %0d gate actual=%b expected=%b",
                         cur_req, cyc, gate_o, exp_q);
            end
        end
    end

    task automatic check(input string req, input logic [NCH-1:0] act,
                         input logic [NCH-1:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, expv);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int addr, input int data);
        wr_en = 1'b1; wr_addr = ADDR_W'(addr); wr_data = CNT_W'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [NCH-1:0] m, input int w);
        trig_r = trig_r | m;
        repeat (w) @(negedge clk);
        trig_r = trig_r & ~m;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        // R1: outputs low from reset; triggers with cleared counts do nothing
        cur_req = "R1";
        check("R1", gate_o, '0);
        pulse('1, 1);
        idle(10);
        check("R1", gate_o, '0);

        // R3: latency of the synchroniser and edge compare
        cur_req = "R3";
        wr(14, 0); wr(15, 1);
        pulse(8'h80, 1);          // pin seen high at posedge 1
        @(negedge clk);           // after posedge 2
        check("R3", gate_o, 8'h00);
        @(negedge clk);           // after posedge 3: accepted, d=0
        check("R3", gate_o, 8'h80);
        idle(6);

        // R4 / R7: sweep of small delay and width pairs on channel 0
        for (int d = 0; d <= 4; d++) begin
            for (int g = 0; g <= 4; g++) begin
                cur_req = (g == 0) ? "R7" : "R4";
                wr(0, d); wr(1, g);
                pulse(8'h01, 1);
                idle(d + g + 6);
            end
        end

        // R2: address map, distinct counts per channel fired one at a time
        cur_req = "R2";
        for (int ch = 0; ch < NCH; ch++) begin
            wr(2 * ch, ch + 1);
            wr(2 * ch + 1, 2 * ch + 1);
        end
        for (int ch = 0; ch < NCH; ch++) begin
            pulse(NCH'(1) << ch, 1);
            idle(3 * ch + 8);
        end
        wr(6, 2);                 // change only channel 3 delay
        pulse(8'h0C, 1);
        idle(20);

        // R5: triggers repeated through wait and pulse phases
        cur_req = "R5";
        wr(4, 3); wr(5, 4);
        for (int k = 0; k < 6; k++) begin
            pulse(8'h04, 1);
            idle(1);
        end
        idle(15);

        // R6: second trigger swept across the end of the pulse
        cur_req = "R6";
        wr(2, 2); wr(3, 3);
        for (int gap = 1; gap <= 10; gap++) begin
            pulse(8'h02, 1);
            idle(gap);
            pulse(8'h02, 1);
            idle(14);
        end

        // R8: writes during busy only affect the next trigger
        cur_req = "R8";
        wr(8, 2); wr(9, 2);
        pulse(8'h10, 1);
        idle(1);
        wr(8, 5); wr(9, 1);
        idle(10);
        pulse(8'h10, 1);
        idle(12);

        // R9: held trigger accepted once
        cur_req = "R9";
        wr(12, 1); wr(13, 2);
        pulse(8'h40, 20);
        idle(10);

        // R10: all channels at once with different counts
        cur_req = "R10";
        for (int ch = 0; ch < NCH; ch++) begin
            wr(2 * ch, ch);
            wr(2 * ch + 1, ch + 1);
        end
        pulse('1, 1);
        idle(25);

        // R1: reset in the middle of activity clears everything
        cur_req = "R1";
        pulse('1, 1);
        idle(4);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        check("R1", gate_o, '0);
        pulse('1, 1);
        idle(20);
        check("R1", gate_o, '0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule